// File: doc/BRIEF.md
# Shared Reorder Buffer Occupancy Governor

Several hardware threads share one reorder buffer. This block keeps the occupancy of that buffer, per thread and in total, and it limits how many entries each thread may hold. Dispatch, retire and squash events arrive tagged with a thread index. A dispatch adds one entry, a retire removes one, and a squash removes a given number of entries from one thread in a single cycle. The block only counts entries. It stores no instruction payload.

Each thread's entry limit (its cap) comes from a sharing policy and from the current set of active threads. The policies are: every thread may use the whole buffer; the buffer is split evenly among the active threads; or every thread gets a fixed threshold. The caps are recomputed every cycle from the policy inputs, so they follow changes in the active-thread mask. Events that are not allowed leave the counts unchanged and raise a one-cycle error flag. The front end reads the free-entry counts and the full flags to decide whether it may dispatch.

Top module: `rob_share_gov`

## Requirements
- R1: After reset all counts are zero and every cap equals CAPACITY, which is the dynamic policy with thread 0 as the only active thread. Every per-thread free count and the total free count read CAPACITY. Both full flags and errFlag are low.
- R2: An accepted dispatch raises the thread count and the total count by one. An accepted retire lowers both by one. A dispatch and a retire on the same thread in the same cycle leave both counts unchanged. The per-thread free count is cap minus count. totalFree is CAPACITY minus the total count.
- R3: Policy code 0 (dynamic) sets every cap to CAPACITY.
- R4: Policy code 1 (partitioned) gives each active thread a cap of CAPACITY divided by the number of active threads, using integer division. Inactive threads get CAPACITY/NUM_THREADS. An empty mask gives every thread CAPACITY/NUM_THREADS.
- R5: Policy code 2 (threshold) sets every cap to the smaller of thresholdVal and CAPACITY. When exactly one thread is active, that thread's cap is CAPACITY instead.
- R6: Caps are registered. A change of mask, policy or threshold is visible on the free counts after the next rising clock edge, and not before it.
- R7: Policy code 3 is illegal. While it is applied, the caps hold their values and errFlag is high on the following cycle.
- R8: A dispatch is rejected when the thread's count is at or above its cap, or when the buffer holds CAPACITY entries. A rejected dispatch changes no count and sets errFlag.
- R9: A retire is rejected when its thread's count is zero, or when a squash targets the same thread in the same cycle. A rejected retire changes no count and sets errFlag.
- R10: A squash removes squashCount entries from one thread, and from the total, in one cycle. A squash with squashCount larger than the thread's count is rejected: no count changes and errFlag is set.
- R11: A per-thread free count saturates at zero when the cap is below the count. threadFull[i] is high when count i is at or above cap i. globalFull is high when the total count equals CAPACITY.
- R12: errFlag is registered. It is high exactly in the cycle after a rejected event or an illegal policy, and low after any cycle that had neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch event |
| dispTid | input | TW | Thread of the dispatch |
| retValid | input | 1 | Retire event |
| retTid | input | TW | Thread of the retire |
| squashValid | input | 1 | Squash event |
| squashTid | input | TW | Thread of the squash |
| squashCount | input | CW | Entries removed by the squash |
| activeMask | input | NUM_THREADS | One bit per active thread |
| policySel | input | 2 | Sharing policy code: 0 dynamic, 1 partitioned, 2 threshold, 3 illegal |
| thresholdVal | input | CW | Cap used by the threshold policy |
| threadFree | output | NUM_THREADS*CW | Free count of thread i at bits [i*CW +: CW] |
| totalFree | output | CW | Free entries in the whole buffer |
| threadFull | output | NUM_THREADS | Thread count at or above its cap |
| globalFull | output | 1 | Buffer holds CAPACITY entries |
| errFlag | output | 1 | Rejected event or illegal policy in the previous cycle |

## Verification
The counting path is tested with:
- single dispatches and retires spread over several threads;
- a dispatch paired with a retire on the same thread;
- a squash paired with a retire on the same thread.

These patterns separate per-thread accounting from total accounting, and show the order in which same-cycle events are resolved.

The cap logic is tested by moving through several active masks under each policy. One-, two-, three- and zero-thread masks under partitioning expose the division and the default share. Under the threshold policy, a single active thread and a threshold above capacity expose the override and the clamp.

Rejection is tested by filling one thread to its cap, filling the whole buffer, retiring from an empty thread and squashing more entries than a thread holds. Each of these must raise the flag and leave the counts unchanged.

// File: rtl/rob_share_pkg.sv
package rob_share_pkg;

  typedef enum logic [1:0] {
    POL_DYNAMIC   = 2'd0,
    POL_PARTITION = 2'd1,
    POL_THRESHOLD = 2'd2,
    POL_INVALID   = 2'd3
  } policy_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic dispEn;
    logic retEn;
    logic sqEn;
    logic capLoad;
  } occStrobe_t;

endpackage

// File: rtl/rob_share_ctrl.sv
module rob_share_ctrl
  import rob_share_pkg::*;
#(
  parameter int NT  = 4,
  parameter int CAP = 32,
  parameter int CW  = 6,
  parameter int TW  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dispValid,
  input  logic [TW-1:0]          dispTid,
  input  logic                   retValid,
  input  logic [TW-1:0]          retTid,
  input  logic                   squashValid,
  input  logic [TW-1:0]          squashTid,
  input  logic [CW-1:0]          squashCount,
  input  logic [1:0]             policySel,
  input  logic [NT-1:0][CW-1:0]  threadCnt,
  input  logic [NT-1:0][CW-1:0]  threadCap,
  input  logic [CW-1:0]          totalCnt,
  output occStrobe_t             stb,
  output logic                   errFlag
);

  localparam logic [CW-1:0] CAP_V = CW'(CAP);

  logic dispBlock, retBlock, sqBlock, polBad, anyErr;

  always_comb begin
    dispBlock = (threadCnt[dispTid] >= threadCap[dispTid]) || (totalCnt >= CAP_V);
    retBlock  = (threadCnt[retTid] == '0) || (squashValid && (squashTid == retTid));
    sqBlock   = squashCount > threadCnt[squashTid];
    polBad    = policy_e'(policySel) == POL_INVALID;

    stb.dispEn  = dispValid   && !dispBlock;
    stb.retEn   = retValid    && !retBlock;
    stb.sqEn    = squashValid && !sqBlock;
    stb.capLoad = !polBad;

    anyErr = polBad || (dispValid && dispBlock) || (retValid && retBlock)
             || (squashValid && sqBlock);
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= anyErr;
  end

endmodule

// File: rtl/rob_share_dp.sv
module rob_share_dp
  import rob_share_pkg::*;
#(
  parameter int NT  = 4,
  parameter int CAP = 32,
  parameter int CW  = 6,
  parameter int TW  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  occStrobe_t             stb,
  input  logic [TW-1:0]          dispTid,
  input  logic [TW-1:0]          retTid,
  input  logic [TW-1:0]          squashTid,
  input  logic [CW-1:0]          squashCount,
  input  logic [NT-1:0]          activeMask,
  input  logic [1:0]             policySel,
  input  logic [CW-1:0]          thresholdVal,
  output logic [NT-1:0][CW-1:0]  threadCnt,
  output logic [NT-1:0][CW-1:0]  threadCap,
  output logic [CW-1:0]          totalCnt,
  output logic [NT-1:0][CW-1:0]  threadFreeArr,
  output logic [CW-1:0]          totalFree,
  output logic [NT-1:0]          threadFull,
  output logic                   globalFull
);

  localparam logic [CW-1:0] CAP_V  = CW'(CAP);
  localparam logic [CW-1:0] BASE_V = CW'(CAP / NT);

  int             activeNum;
  logic [CW-1:0]  shareActive;
  logic [CW-1:0]  thrClamp;
  logic [NT-1:0][CW-1:0] capNext;

  // Shared cap terms
  always_comb begin
    activeNum   = $countones(activeMask);
    shareActive = BASE_V;
    for (int k = 1; k <= NT; k++) begin
      if (activeNum == k) shareActive = CW'(CAP / k);
    end
    thrClamp = (thresholdVal > CAP_V) ? CAP_V : thresholdVal;
  end

  for (genvar i = 0; i < NT; i++) begin : g_thread
    logic [CW:0] cntWide;

    always_comb begin
      case (policy_e'(policySel))
        POL_DYNAMIC:   capNext[i] = CAP_V;
        POL_PARTITION: capNext[i] = activeMask[i] ? shareActive : BASE_V;
        POL_THRESHOLD: capNext[i] = (activeNum == 1 && activeMask[i]) ? CAP_V : thrClamp;
        default:       capNext[i] = threadCap[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)            threadCap[i] <= CAP_V;
      else if (stb.capLoad) threadCap[i] <= capNext[i];
    end

    always_comb begin
      cntWide = {1'b0, threadCnt[i]};
      if (stb.dispEn && dispTid == TW'(i))   cntWide = cntWide + 1'b1;
      if (stb.retEn  && retTid  == TW'(i))   cntWide = cntWide - 1'b1;
      if (stb.sqEn   && squashTid == TW'(i)) cntWide = cntWide - {1'b0, squashCount};
    end

    always_ff @(posedge clk) begin
      if (!rstN) threadCnt[i] <= '0;
      else       threadCnt[i] <= cntWide[CW-1:0];
    end

    assign threadFull[i]    = threadCnt[i] >= threadCap[i];
    assign threadFreeArr[i] = threadFull[i] ? '0 : threadCap[i] - threadCnt[i];
  end

  logic [CW:0] totWide;
  always_comb begin
    totWide = {1'b0, totalCnt};
    if (stb.dispEn) totWide = totWide + 1'b1;
    if (stb.retEn)  totWide = totWide - 1'b1;
    if (stb.sqEn)   totWide = totWide - {1'b0, squashCount};
  end

  always_ff @(posedge clk) begin
    if (!rstN) totalCnt <= '0;
    else       totalCnt <= totWide[CW-1:0];
  end

  assign totalFree  = CAP_V - totalCnt;
  assign globalFull = totalCnt == CAP_V;

endmodule

// File: rtl/rob_share_gov.sv
module rob_share_gov
  import rob_share_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CAPACITY    = 32,
  localparam int CW = $clog2(CAPACITY + 1),
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      dispValid,
  input  logic [TW-1:0]             dispTid,
  input  logic                      retValid,
  input  logic [TW-1:0]             retTid,
  input  logic                      squashValid,
  input  logic [TW-1:0]             squashTid,
  input  logic [CW-1:0]             squashCount,
  input  logic [NUM_THREADS-1:0]    activeMask,
  input  logic [1:0]                policySel,
  input  logic [CW-1:0]             thresholdVal,
  output logic [NUM_THREADS*CW-1:0] threadFree,
  output logic [CW-1:0]             totalFree,
  output logic [NUM_THREADS-1:0]    threadFull,
  output logic                      globalFull,
  output logic                      errFlag
);

  occStrobe_t                     stb;
  logic [NUM_THREADS-1:0][CW-1:0] threadCnt;
  logic [NUM_THREADS-1:0][CW-1:0] threadCap;
  logic [NUM_THREADS-1:0][CW-1:0] threadFreeArr;
  logic [CW-1:0]                  totalCnt;

  rob_share_ctrl #(.NT(NUM_THREADS), .CAP(CAPACITY), .CW(CW), .TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispTid(dispTid),
    .retValid(retValid), .retTid(retTid),
    .squashValid(squashValid), .squashTid(squashTid), .squashCount(squashCount),
    .policySel(policySel),
    .threadCnt(threadCnt), .threadCap(threadCap), .totalCnt(totalCnt),
    .stb(stb), .errFlag(errFlag)
  );

  rob_share_dp #(.NT(NUM_THREADS), .CAP(CAPACITY), .CW(CW), .TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .dispTid(dispTid), .retTid(retTid),
    .squashTid(squashTid), .squashCount(squashCount),
    .activeMask(activeMask), .policySel(policySel), .thresholdVal(thresholdVal),
    .threadCnt(threadCnt), .threadCap(threadCap), .totalCnt(totalCnt),
    .threadFreeArr(threadFreeArr), .totalFree(totalFree),
    .threadFull(threadFull), .globalFull(globalFull)
  );

  assign threadFree = threadFreeArr;

endmodule

// File: rtl/rob_share_chk.sv
module rob_share_chk #(
  parameter int NT  = 4,
  parameter int CAP = 32,
  parameter int CW  = 6,
  parameter int TW  = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  dispValid,
  input logic [TW-1:0]         dispTid,
  input logic                  retValid,
  input logic [TW-1:0]         retTid,
  input logic                  squashValid,
  input logic [TW-1:0]         squashTid,
  input logic [CW-1:0]         squashCount,
  input logic [1:0]            policySel,
  input logic [NT-1:0][CW-1:0] threadCnt,
  input logic [CW-1:0]         totalCnt,
  input logic [CW-1:0]         totalFree,
  input logic                  globalFull,
  input logic                  errFlag
);

  logic [CW+TW:0] sumCnt;
  always_comb begin
    sumCnt = '0;
    for (int i = 0; i < NT; i++) sumCnt = sumCnt + (CW+TW+1)'(threadCnt[i]);
  end

  p_total_sum_r2: assert property (@(posedge clk) disable iff (!rstN)
    (CW+TW+1)'(totalCnt) == sumCnt);

  p_bad_policy_r7: assert property (@(posedge clk) disable iff (!rstN)
    policySel == 2'd3 |=> errFlag);

  p_full_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && globalFull && !retValid && !squashValid) |=> (totalFree == '0 && errFlag));

  p_empty_retire_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && threadCnt[retTid] == '0) |=> errFlag);

  p_squash_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (squashValid && !dispValid && !retValid && squashCount <= threadCnt[squashTid])
    |=> totalCnt == $past(totalCnt) - $past(squashCount));

  p_err_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (policySel != 2'd3 && !dispValid && !retValid && !squashValid) |=> !errFlag);

endmodule

bind rob_share_gov rob_share_chk #(.NT(NUM_THREADS), .CAP(CAPACITY), .CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rstN(rstN),
  .dispValid(dispValid), .dispTid(dispTid),
  .retValid(retValid), .retTid(retTid),
  .squashValid(squashValid), .squashTid(squashTid), .squashCount(squashCount),
  .policySel(policySel), .threadCnt(threadCnt), .totalCnt(totalCnt),
  .totalFree(totalFree), .globalFull(globalFull), .errFlag(errFlag)
);

// File: tb/rob_share_gov_tb.sv
`timescale 1ns/1ps
module rob_share_gov_tb;

  localparam int NT  = 4;
  localparam int CAP = 32;
  localparam int CW  = $clog2(CAP + 1);
  localparam int TW  = 2;

  logic clk = 1'b0;
  logic rstN;
  logic dispValid, retValid, squashValid;
  logic [TW-1:0] dispTid, retTid, squashTid;
  logic [CW-1:0] squashCount, thresholdVal;
  logic [NT-1:0] activeMask;
  logic [1:0] policySel;
  logic [NT*CW-1:0] threadFree;
  logic [CW-1:0] totalFree;
  logic [NT-1:0] threadFull;
  logic globalFull, errFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rob_share_gov #(.NUM_THREADS(NT), .CAPACITY(CAP)) u_dut (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispTid(dispTid),
    .retValid(retValid), .retTid(retTid),
    .squashValid(squashValid), .squashTid(squashTid), .squashCount(squashCount),
    .activeMask(activeMask), .policySel(policySel), .thresholdVal(thresholdVal),
    .threadFree(threadFree), .totalFree(totalFree),
    .threadFull(threadFull), .globalFull(globalFull), .errFlag(errFlag)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int freeOf(int t);
    return int'(threadFree[t*CW +: CW]);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; dispValid = 0; retValid = 0; squashValid = 0;
    dispTid = '0; retTid = '0; squashTid = '0; squashCount = '0;
    activeMask = 4'b0001; policySel = 2'd0; thresholdVal = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(bit dv, int dt, bit rv, int rt, bit sv, int st, int sc);
    @(negedge clk);
    dispValid = dv; dispTid = TW'(dt);
    retValid = rv; retTid = TW'(rt);
    squashValid = sv; squashTid = TW'(st); squashCount = CW'(sc);
    @(negedge clk);
    dispValid = 0; retValid = 0; squashValid = 0;
  endtask

  task automatic disp(int t, int n);
    for (int k = 0; k < n; k++) drive(1, t, 0, 0, 0, 0, 0);
  endtask

  task automatic setPolicy(logic [NT-1:0] m, int p, int thr);
    @(negedge clk);
    activeMask = m; policySel = 2'(p); thresholdVal = CW'(thr);
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    for (int t = 0; t < NT; t++) check("R1 free", freeOf(t), CAP);
    check("R1 totalFree", int'(totalFree), CAP);
    check("R1 flags", int'({threadFull, globalFull, errFlag}), 0);
  endtask

  task automatic testCounting();
    doReset();
    disp(0, 3); disp(1, 2);
    check("R2 free t0", freeOf(0), 29);
    check("R2 free t1", freeOf(1), 30);
    check("R2 totalFree", int'(totalFree), 27);
    drive(0, 0, 1, 1, 0, 0, 0);
    check("R2 retire t1", freeOf(1), 31);
    check("R2 retire total", int'(totalFree), 28);
    drive(1, 0, 1, 0, 0, 0, 0);
    check("R2 disp+ret t0", freeOf(0), 29);
    check("R2 disp+ret total", int'(totalFree), 28);
    check("R2 disp+ret err", int'(errFlag), 0);
  endtask

  task automatic testPartition();
    doReset();
    disp(0, 3); disp(1, 2);
    @(negedge clk);
    activeMask = 4'b0011; policySel = 2'd1;
    #1 check("R6 before edge", freeOf(0), 29);
    @(negedge clk);
    check("R4 two active t0", freeOf(0), 13);
    check("R4 two active t1", freeOf(1), 14);
    check("R4 inactive t2", freeOf(2), 8);
    setPolicy(4'b0111, 1, 0);
    check("R4 three active t0", freeOf(0), 7);
    check("R4 three active t2", freeOf(2), 10);
    setPolicy(4'b0000, 1, 0);
    check("R4 empty mask t0", freeOf(0), 5);
    setPolicy(4'b0001, 0, 0);
    check("R3 dynamic t3", freeOf(3), 32);
    check("R3 dynamic t1", freeOf(1), 30);
  endtask

  task automatic testThreshold();
    doReset();
    disp(0, 3);
    setPolicy(4'b0111, 2, 5);
    check("R5 thr t0", freeOf(0), 2);
    check("R5 thr t1", freeOf(1), 5);
    setPolicy(4'b0001, 2, 5);
    check("R5 single active t0", freeOf(0), 29);
    check("R5 single active t1", freeOf(1), 5);
    setPolicy(4'b0011, 2, 40);
    check("R5 clamp t0", freeOf(0), 29);
    check("R5 clamp t1", freeOf(1), 32);
  endtask

  task automatic testCapLimit();
    doReset();
    setPolicy(4'b0011, 2, 5);
    disp(1, 5);
    check("R11 t1 at cap free", freeOf(1), 0);
    check("R11 t1 full", int'(threadFull[1]), 1);
    drive(1, 1, 0, 0, 0, 0, 0);
    check("R8 over cap err", int'(errFlag), 1);
    check("R8 over cap total", int'(totalFree), 27);
    @(negedge clk);
    check("R12 err clears", int'(errFlag), 0);
  endtask

  task automatic testIllegal();
    doReset();
    setPolicy(4'b0011, 1, 0);
    disp(0, 1);
    check("R4 t0 part", freeOf(0), 15);
    setPolicy(4'b0111, 3, 0);
    check("R7 err", int'(errFlag), 1);
    check("R7 t0 held", freeOf(0), 15);
    check("R7 t2 held", freeOf(2), 8);
    setPolicy(4'b0111, 1, 0);
    check("R12 err low", int'(errFlag), 0);
    check("R4 t2 after legal", freeOf(2), 10);
  endtask

  task automatic testSquash();
    doReset();
    disp(0, 4); disp(2, 3);
    drive(0, 0, 0, 0, 1, 2, 2);
    check("R10 squash t2", freeOf(2), 31);
    check("R10 squash total", int'(totalFree), 27);
    drive(0, 0, 0, 0, 1, 0, 5);
    check("R10 over squash err", int'(errFlag), 1);
    check("R10 over squash t0", freeOf(0), 28);
    drive(0, 0, 0, 0, 1, 0, 4);
    check("R10 squash all t0", freeOf(0), 32);
    check("R10 squash all err", int'(errFlag), 0);
  endtask

  task automatic testRetireReject();
    doReset();
    drive(0, 0, 1, 3, 0, 0, 0);
    check("R9 empty retire err", int'(errFlag), 1);
    check("R9 empty retire t3", freeOf(3), 32);
    check("R9 empty retire total", int'(totalFree), 32);
    disp(1, 2);
    drive(0, 0, 1, 1, 1, 1, 1);
    check("R9 retire vs squash err", int'(errFlag), 1);
    check("R9 retire vs squash t1", freeOf(1), 31);
  endtask

  task automatic testGlobalFull();
    doReset();
    disp(0, CAP);
    check("R11 totalFree zero", int'(totalFree), 0);
    check("R11 globalFull", int'(globalFull), 1);
    drive(1, 1, 0, 0, 0, 0, 0);
    check("R8 full err", int'(errFlag), 1);
    check("R8 full t1", freeOf(1), 32);
    check("R8 full total", int'(totalFree), 0);
    setPolicy(4'b0011, 1, 0);
    check("R11 saturate t0", freeOf(0), 0);
    check("R11 t0 full", int'(threadFull[0]), 1);
  endtask

  initial begin
    rstN = 1'b0;
    testReset();
    testCounting();
    testPartition();
    testThreshold();
    testCapLimit();
    testIllegal();
    testSquash();
    testRetireReject();
    testGlobalFull();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule